// File: doc/BRIEF.md
# Memory-Mapped Character Terminal Port

This block sits on a simple synchronous processor bus and gives software one receive channel and one transmit channel for characters. The channels are reached through four word registers inside a fixed address window. A character that arrives from the keyboard side is held until software reads it. A character that software writes is handed to the display side and held there until that side acknowledges it. Each channel has a ready flag and an interrupt-enable flag. The block drives a single level-sensitive interrupt line whenever an enabled channel is ready.

Software can poll the ready bit of either control register, or it can set the enable bits and wait for the interrupt line. The enable bits are changed by a read-modify-write of a control register. The ready flags change only through the data-register handshakes, so a control-register write never disturbs them.

Top module: `kbd_term_mmio`

## Requirements
- R1: An access takes effect only when address bits [31:8] equal those of the base (default 0xF000_0000). A read outside the window returns zero and clears no flag. A write outside the window changes nothing.
- R2: Inside the window the registers sit at these offsets: 0x0 receive control, 0x4 receive data, 0x8 transmit control, 0xC transmit data. A read at any other offset returns zero, and a write there changes no state.
- R3: A control-register read returns the ready flag in bit 0 and the interrupt-enable flag in bit 1. All other bits read as zero.
- R4: A control-register write copies write-data bit 1 into that channel's enable flag. The ready flag is not affected, whatever write-data bit 0 holds.
- R5: When `key_valid` is high at a clock edge, `key_char` is loaded into the receive data register and the receive ready flag is set. A newer character replaces an unread older one.
- R6: A read of receive data returns the character zero-extended to 32 bits and clears receive ready. If `key_valid` is high in the same cycle, the read returns the old character and ready stays set with the new one.
- R7: A write of transmit data clears transmit ready. From the next cycle, `disp_char` holds write-data bits [7:0] and `disp_valid` is high. A read of transmit data returns that last byte in bits [7:0].
- R8: `disp_ack` sets transmit ready at the next edge. A transmit-data write in the same cycle takes priority, and ready stays clear. An acknowledge while ready is already set has no effect.
- R9: `irq` is high exactly when (receive ready and receive enable) or (transmit ready and transmit enable).
- R10: `bus_rdata` is loaded at the edge that samples `bus_rd`, so it is valid in the cycle that follows. It holds its value until the next read.
- R11: After reset, receive ready is 0, transmit ready is 1, both enables are 0, `disp_char` is 0, `bus_rdata` is 0, `disp_valid` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| key_valid | input | 1 | New character present on key_char |
| key_char | input | 8 | Character from the keyboard side |
| disp_valid | output | 1 | Transmit byte waiting for the display side |
| disp_char | output | 8 | Last byte written for display |
| disp_ack | input | 1 | Display side has taken the byte |
| irq | output | 1 | Level interrupt request |

## Verification
Every stimulus is sampled at a single rising edge. The flags, `irq`, `disp_valid` and `disp_char` show the result of that edge, and `bus_rdata` holds the value read at the edge that took the read strobe. There is therefore no added delay. The bench drives each stimulus at the falling edge, steps a reference model across the rising edge, and compares every output 1 ns after that edge. Cycles without a read also check that the read data still holds its last value.

// File: rtl/kt_pkg.sv
package kt_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RX_CTRL,
        SEL_RX_DATA,
        SEL_TX_CTRL,
        SEL_TX_DATA
    } sel_e;

    // register offsets inside the window; software depends on them
    localparam int unsigned OFF_RX_CTRL = 32'h0;
    localparam int unsigned OFF_RX_DATA = 32'h4;
    localparam int unsigned OFF_TX_CTRL = 32'h8;
    localparam int unsigned OFF_TX_DATA = 32'hC;

    // control register bit positions
    localparam int unsigned BIT_RDY = 0;
    localparam int unsigned BIT_IE  = 1;

endpackage

// File: rtl/kt_decode.sv
module kt_decode
    import kt_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned WIN_BITS = 8,
    parameter logic [ADDR_W-1:0] BASE = 32'hF000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);
    localparam int unsigned TAG_W = ADDR_W - WIN_BITS;

    logic [TAG_W-1:0]    tag;
    logic [WIN_BITS-1:0] off;

    always_comb begin
        tag = addr[ADDR_W-1:WIN_BITS];
        off = addr[WIN_BITS-1:0];
        sel = SEL_NONE;
        if (tag == BASE[ADDR_W-1:WIN_BITS]) begin
            case (off)
                WIN_BITS'(OFF_RX_CTRL): sel = SEL_RX_CTRL;
                WIN_BITS'(OFF_RX_DATA): sel = SEL_RX_DATA;
                WIN_BITS'(OFF_TX_CTRL): sel = SEL_TX_CTRL;
                WIN_BITS'(OFF_TX_DATA): sel = SEL_TX_DATA;
                default:                sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/kt_rx_chan.sv
module kt_rx_chan #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_char,
    input  logic              ctrl_wr,
    input  logic              ie_in,
    input  logic              data_rd,
    output logic              rdy,
    output logic              ie,
    output logic [CHAR_W-1:0] ch
);
    typedef struct packed {
        logic              rdy;
        logic              ie;
        logic [CHAR_W-1:0] ch;
    } rx_st_t;

    rx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) st_d.ie = ie_in;
        if (key_valid) begin
            st_d.ch  = key_char;
            st_d.rdy = 1'b1;
        end else if (data_rd) begin
            st_d.rdy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdy = st_q.rdy;
    assign ie  = st_q.ie;
    assign ch  = st_q.ch;

    // R5
    rx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> (rdy && ch == $past(key_char)));
    // R6
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !key_valid) |=> !rdy);
    // R4
    rx_ie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(ie));
endmodule

// File: rtl/kt_tx_chan.sv
module kt_tx_chan #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              ie_in,
    input  logic              data_wr,
    input  logic [CHAR_W-1:0] wchar,
    input  logic              disp_ack,
    output logic              rdy,
    output logic              ie,
    output logic [CHAR_W-1:0] ch
);
    typedef struct packed {
        logic              rdy;
        logic              ie;
        logic [CHAR_W-1:0] ch;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) st_d.ie = ie_in;
        if (data_wr) begin
            st_d.ch  = wchar;
            st_d.rdy = 1'b0;
        end else if (disp_ack) begin
            st_d.rdy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.rdy <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy = st_q.rdy;
    assign ie  = st_q.ie;
    assign ch  = st_q.ch;

    // R7
    tx_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (!rdy && ch == $past(wchar)));
    // R8
    tx_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_ack && !data_wr) |=> rdy);
    // R4
    tx_ie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(ie));
endmodule

// File: rtl/kbd_term_mmio.sv
module kbd_term_mmio
    import kt_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CHAR_W   = 8,
    parameter int unsigned WIN_BITS = 8,
    parameter logic [ADDR_W-1:0] BASE = 32'hF000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_char,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_char,
    input  logic              disp_ack,
    output logic              irq
);
    sel_e sel;

    logic              rx_rdy, rx_ie, tx_rdy, tx_ie;
    logic [CHAR_W-1:0] rx_ch, tx_ch;
    logic              rx_ctrl_wr, tx_ctrl_wr, rx_data_rd, tx_data_wr;
    logic [DATA_W-1:0] rd_val;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    kt_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BASE(BASE)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign rx_ctrl_wr = bus_wr && (sel == SEL_RX_CTRL);
    assign tx_ctrl_wr = bus_wr && (sel == SEL_TX_CTRL);
    assign rx_data_rd = bus_rd && (sel == SEL_RX_DATA);
    assign tx_data_wr = bus_wr && (sel == SEL_TX_DATA);

    kt_rx_chan #(.CHAR_W(CHAR_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (key_valid),
        .key_char  (key_char),
        .ctrl_wr   (rx_ctrl_wr),
        .ie_in     (bus_wdata[BIT_IE]),
        .data_rd   (rx_data_rd),
        .rdy       (rx_rdy),
        .ie        (rx_ie),
        .ch        (rx_ch)
    );

    kt_tx_chan #(.CHAR_W(CHAR_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (tx_ctrl_wr),
        .ie_in    (bus_wdata[BIT_IE]),
        .data_wr  (tx_data_wr),
        .wchar    (bus_wdata[CHAR_W-1:0]),
        .disp_ack (disp_ack),
        .rdy      (tx_rdy),
        .ie       (tx_ie),
        .ch       (tx_ch)
    );

    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_RX_CTRL: begin
                rd_val[BIT_RDY] = rx_rdy;
                rd_val[BIT_IE]  = rx_ie;
            end
            SEL_TX_CTRL: begin
                rd_val[BIT_RDY] = tx_rdy;
                rd_val[BIT_IE]  = tx_ie;
            end
            SEL_RX_DATA: rd_val = DATA_W'(rx_ch);
            SEL_TX_DATA: rd_val = DATA_W'(tx_ch);
            default:     rd_val = '0;
        endcase
        st_d = st_q;
        if (bus_rd) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign disp_valid = !tx_rdy;
    assign disp_char  = tx_ch;
    assign irq        = (rx_rdy && rx_ie) || (tx_rdy && tx_ie);

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    // R1
    outside_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_NONE) |=> ($stable(rx_ie) && $stable(tx_ie)));
    // R2
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_NONE) |=> (bus_rdata == '0));
endmodule

// File: tb/kbd_term_mmio_bench.sv
`timescale 1ns/1ps
module kbd_term_mmio_bench;
    localparam logic [31:0] BASE = 32'hF000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        key_valid = 1'b0;
    logic [7:0]  key_char = '0;
    logic        disp_valid;
    logic [7:0]  disp_char;
    logic        disp_ack = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic       m_rx_rdy = 0, m_rx_ie = 0, m_tx_rdy = 1, m_tx_ie = 0;
    logic [7:0] m_rx_ch = 0, m_tx_ch = 0;
    logic [31:0] m_rdata = 0;

    always #4 clk = ~clk;

    kbd_term_mmio u_kbd_term_mmio (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .key_valid(key_valid), .key_char(key_char), .disp_valid(disp_valid),
        .disp_char(disp_char), .disp_ack(disp_ack), .irq(irq)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic in_win(logic [31:0] a);
        return a[31:8] == BASE[31:8];
    endfunction

    function automatic logic [31:0] ref_read(logic [31:0] a);
        if (!in_win(a)) return 32'h0;
        case (a[7:0])
            8'h0: return {30'h0, m_rx_ie, m_rx_rdy};
            8'h4: return {24'h0, m_rx_ch};
            8'h8: return {30'h0, m_tx_ie, m_tx_rdy};
            8'hC: return {24'h0, m_tx_ch};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag(logic [31:0] a);
        if (!in_win(a)) return "R1";
        case (a[7:0])
            8'h0, 8'h8: return "R3";
            8'h4: return "R6";
            8'hC: return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic step(logic [31:0] a, logic rd, logic wr, logic [31:0] wd,
                        logic kv, logic [7:0] kc, logic ack, string tag);
        logic hit;
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
        key_valid = kv; key_char = kc; disp_ack = ack;
        hit = in_win(a);
        if (rd) m_rdata = ref_read(a);
        if (kv) begin m_rx_ch = kc; m_rx_rdy = 1'b1; end
        else if (rd && hit && a[7:0] == 8'h4) m_rx_rdy = 1'b0;
        if (wr && hit && a[7:0] == 8'h0) m_rx_ie = wd[1];
        if (wr && hit && a[7:0] == 8'h8) m_tx_ie = wd[1];
        if (wr && hit && a[7:0] == 8'hC) begin m_tx_ch = wd[7:0]; m_tx_rdy = 1'b0; end
        else if (ack) m_tx_rdy = 1'b1;
        @(posedge clk);
        #1;
        chk(tag != "" ? tag : (rd ? rd_tag(a) : "R10"), "rdata", bus_rdata, m_rdata);
        chk("R9", "irq", 32'(irq), 32'((m_rx_rdy && m_rx_ie) || (m_tx_rdy && m_tx_ie)));
        chk("R7", "disp_char", 32'(disp_char), 32'(m_tx_ch));
        chk("R8", "disp_valid", 32'(disp_valid), 32'(!m_tx_rdy));
    endtask

    task automatic rd_at(logic [7:0] off, string tag);
        step(BASE + 32'(off), 1, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic wr_at(logic [31:0] a, logic [31:0] wd, logic ack, string tag);
        step(a, 0, 1, wd, 0, 0, ack, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk("R11", "rdata", bus_rdata, 32'h0);
        chk("R11", "irq", 32'(irq), 32'h0);
        chk("R11", "disp_valid", 32'(disp_valid), 32'h0);
        chk("R11", "disp_char", 32'(disp_char), 32'h0);
        @(negedge clk); rst_n = 1'b1;

        rd_at(8'h0, "R11");
        rd_at(8'h8, "R11");
        // R4: bit 0 of write data must not set ready
        wr_at(BASE, 32'hFFFF_FFFF, 0, "R4");
        rd_at(8'h0, "R4");
        wr_at(BASE, 32'h0000_0001, 0, "R4");
        rd_at(8'h0, "R4");
        wr_at(BASE, 32'h0000_0002, 0, "R4");
        // R5 load and overwrite
        step(BASE, 0, 0, 0, 1, 8'h41, 0, "R5");
        rd_at(8'h0, "R5");
        step(BASE, 0, 0, 0, 1, 8'h42, 0, "R5");
        step(BASE, 0, 0, 0, 1, 8'h43, 0, "R5");
        rd_at(8'h4, "R5");
        rd_at(8'h0, "R6");
        // R6 read together with a new character
        step(BASE + 4, 1, 0, 0, 0, 0, 0, "R6");
        step(BASE + 4, 1, 0, 0, 1, 8'h44, 0, "R6");
        rd_at(8'h0, "R6");
        rd_at(8'h4, "R6");
        // R1 outside window: no clear, no write
        step(32'hE000_0004, 1, 0, 0, 1, 8'h45, 0, "R1");
        step(32'hE000_0004, 1, 0, 0, 0, 0, 0, "R1");
        wr_at(BASE + 32'h100, 32'h0, 0, "R1");
        rd_at(8'h0, "R1");
        // R2 unmapped offsets
        rd_at(8'h10, "R2");
        rd_at(8'h05, "R2");
        wr_at(BASE + 32'h14, 32'hFFFF_FFFF, 0, "R2");
        rd_at(8'h8, "R2");
        // R7 transmit path
        wr_at(BASE + 8, 32'h2, 0, "R9");
        wr_at(BASE + 32'hC, 32'h1234_5678, 0, "R7");
        rd_at(8'hC, "R7");
        rd_at(8'h8, "R7");
        // R8 write with ack in the same cycle, then plain ack, then idle ack
        wr_at(BASE + 32'hC, 32'h55, 1, "R8");
        rd_at(8'h8, "R8");
        step(BASE, 0, 0, 0, 0, 0, 1, "R8");
        rd_at(8'h8, "R8");
        step(BASE, 0, 0, 0, 0, 0, 1, "R8");
        rd_at(8'h8, "R8");
        // R10 hold without read
        step(BASE, 0, 0, 0, 0, 0, 0, "R10");
        step(BASE + 4, 0, 0, 0, 0, 0, 0, "R10");

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a;
            int pick, op;
            pick = int'($urandom % 8);
            case (pick)
                0, 6:    a = BASE;
                1:       a = BASE + 4;
                2, 7:    a = BASE + 8;
                3:       a = BASE + 32'hC;
                4:       a = BASE + 32'($urandom % 256);
                default: a = 32'($urandom);
            endcase
            op = int'($urandom % 4);
            step(a, op == 1 || op == 3, op == 2, 32'($urandom),
                 ($urandom % 5) == 0, 8'($urandom), ($urandom % 3) == 0, "");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule